// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a single-cycle 32-bit RISC-V core. On every rising clock edge where the current instruction is flagged valid, it replaces the PC with one of four candidates. Those candidates are the sequential address PC+4, the PC-relative jump target (PC plus the J-format immediate), the PC-relative conditional branch target (PC plus the B-format immediate), and the register-indirect jump target (rs1 plus the I-format immediate, with bit 0 cleared).

A small comparator evaluates the branch condition chosen by a 3-bit code against the two register read values. It supports equality and both signed and unsigned ordering, and reduces the result to one take-branch decision. A 2-bit source code is then formed from that decision, the jump-enable bit and the jump-kind select. The upper bit of this code marks a jump, and the lower bit picks between the two targets of each pair. The branch target is used only when the condition holds. Otherwise the counter steps by four.

The decode stage drives the inputs from the instruction word. The PC and PC+4 are returned to fetch and to the link-address path.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is loaded with the parameter `RESET_VEC` (default 0x0000_1000).
- R2: When `inst_valid` is low at a rising edge (and `rst` is low), the PC keeps its value, whatever the other inputs are.
- R3: With `inst_valid` high, `jump_en` low and no branch taken, the PC advances by 4. The output `pc_plus4` always equals `pc` + 4 (modulo 2^32).
- R4: With `inst_valid` and `jump_en` high and `jalr_sel` low, the next PC is `pc` + `imm_j`.
- R5: With `inst_valid`, `jump_en` and `jalr_sel` high, the next PC is (`rs1_val` + `imm_i`) with bit 0 forced to 0.
- R6: `br_sel` code 1 branches when `rs1_val` equals `rs2_val`, and code 2 branches when they differ.
- R7: `br_sel` code 3 branches when `rs1_val` < `rs2_val` as signed two's-complement values. Code 4 branches when `rs1_val` >= `rs2_val` signed, which includes equality.
- R8: `br_sel` code 5 branches when `rs1_val` < `rs2_val` as unsigned values. Code 6 branches when `rs1_val` >= `rs2_val` unsigned, which includes equality.
- R9: A taken branch (with `jump_en` low) loads `pc` + `imm_b`. Codes 0 and 7 never branch, so the PC steps by 4.
- R10: When `jump_en` is high, the branch code has no effect and the jump target is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Current instruction is valid; enables the PC update |
| jump_en | input | 1 | Unconditional jump in progress |
| jalr_sel | input | 1 | Jump kind: 0 = PC-relative, 1 = register-indirect |
| br_sel | input | 3 | Branch condition code (0 none, 1 EQ, 2 NE, 3 LT, 4 GE, 5 LTU, 6 GEU, 7 none) |
| rs1_val | input | XLEN | First register read value (compare operand and indirect base) |
| rs2_val | input | XLEN | Second register read value (compare operand) |
| imm_j | input | XLEN | Sign-extended J-format immediate |
| imm_b | input | XLEN | Sign-extended B-format immediate |
| imm_i | input | XLEN | Sign-extended I-format immediate |
| pc | output | XLEN | Current program counter |
| pc_plus4 | output | XLEN | Current program counter plus 4 |

## Verification
The assertions assume that `rst` is driven to a known level from the first edge, and that the control inputs are never X while `inst_valid` is high. They also assume the decoder never pairs a set jump bit with a meaningful branch code. The one exception is the priority test, where that pairing is made on purpose to show that the jump wins. The bench meets these assumptions by holding reset high from time zero and by changing every input only on the falling edge, as fully specified values. Register-indirect targets use both odd and even sums, so the bit-0 clearing is exercised directly.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;

  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_EQ   = 3'd1,
    BR_NE   = 3'd2,
    BR_LT   = 3'd3,
    BR_GE   = 3'd4,
    BR_LTU  = 3'd5,
    BR_GEU  = 3'd6,
    BR_RSVD = 3'd7
  } br_cond_e;

  // upper bit: jump; lower bit: second target of each pair
  typedef enum logic [1:0] {
    SRC_SEQ  = 2'b00,
    SRC_BR   = 2'b01,
    SRC_JAL  = 2'b10,
    SRC_JALR = 2'b11
  } pc_src_e;

  localparam int unsigned NUM_SRC = 4;

endpackage

// File: rtl/br_compare.sv
module br_compare
  import pcsel_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  br_cond_e          cond,
  input  logic [XLEN-1:0]   op_a,
  input  logic [XLEN-1:0]   op_b,
  output logic              take
);

  localparam int unsigned MSB = XLEN - 1;

  // signed order via an unsigned compare on sign-flipped operands
  function automatic logic lt_signed(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    logic [XLEN-1:0] fa;
    logic [XLEN-1:0] fb;
    fa = {~a[MSB], a[MSB-1:0]};
    fb = {~b[MSB], b[MSB-1:0]};
    return fa < fb;
  endfunction

  logic is_eq;
  logic is_ltu;
  logic is_lts;

  assign is_eq  = (op_a == op_b);
  assign is_ltu = (op_a < op_b);
  assign is_lts = lt_signed(op_a, op_b);

  always_comb begin
    unique case (cond)
      BR_EQ:   take = is_eq;
      BR_NE:   take = ~is_eq;
      BR_LT:   take = is_lts;
      BR_GE:   take = ~is_lts;
      BR_LTU:  take = is_ltu;
      BR_GEU:  take = ~is_ltu;
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/pc_target_gen.sv
module pc_target_gen #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] pc_q,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] imm_j,
  input  logic [XLEN-1:0] imm_b,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] tgt_seq,
  output logic [XLEN-1:0] tgt_br,
  output logic [XLEN-1:0] tgt_jal,
  output logic [XLEN-1:0] tgt_jalr
);

  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  localparam logic [XLEN-1:0] LSB_CLR = ~XLEN'(1);

  function automatic logic [XLEN-1:0] rel_add(input logic [XLEN-1:0] base,
                                              input logic [XLEN-1:0] ofs);
    return base + ofs;
  endfunction

  function automatic logic [XLEN-1:0] ind_target(input logic [XLEN-1:0] base,
                                                 input logic [XLEN-1:0] ofs);
    return rel_add(base, ofs) & LSB_CLR;
  endfunction

  assign tgt_seq  = rel_add(pc_q, STEP);
  assign tgt_br   = rel_add(pc_q, imm_b);
  assign tgt_jal  = rel_add(pc_q, imm_j);
  assign tgt_jalr = ind_target(rs1_val, imm_i);

endmodule

// File: rtl/pc_src_select.sv
module pc_src_select
  import pcsel_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            jump_en,
  input  logic            jalr_sel,
  input  logic            take_branch,
  input  logic [XLEN-1:0] tgt_seq,
  input  logic [XLEN-1:0] tgt_br,
  input  logic [XLEN-1:0] tgt_jal,
  input  logic [XLEN-1:0] tgt_jalr,
  output pc_src_e         src,
  output logic [XLEN-1:0] pc_d
);

  logic [XLEN-1:0] cand [NUM_SRC];

  always_comb begin
    if (jump_en) src = jalr_sel ? SRC_JALR : SRC_JAL;
    else         src = take_branch ? SRC_BR : SRC_SEQ;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cand
    if (g == int'(SRC_SEQ))      begin : g_s assign cand[g] = tgt_seq;  end
    else if (g == int'(SRC_BR))  begin : g_b assign cand[g] = tgt_br;   end
    else if (g == int'(SRC_JAL)) begin : g_j assign cand[g] = tgt_jal;  end
    else                         begin : g_r assign cand[g] = tgt_jalr; end
  end

  assign pc_d = cand[src];

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcsel_pkg::*;
#(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inst_valid,
  input  logic            jump_en,
  input  logic            jalr_sel,
  input  logic [2:0]      br_sel,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm_j,
  input  logic [XLEN-1:0] imm_b,
  input  logic [XLEN-1:0] imm_i,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] pc_plus4
);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] tgt_seq;
  logic [XLEN-1:0] tgt_br;
  logic [XLEN-1:0] tgt_jal;
  logic [XLEN-1:0] tgt_jalr;
  logic            take_branch;
  pc_src_e         pc_src;

  br_compare #(.XLEN(XLEN)) u_cmp (
    .cond (br_cond_e'(br_sel)),
    .op_a (rs1_val),
    .op_b (rs2_val),
    .take (take_branch)
  );

  pc_target_gen #(.XLEN(XLEN)) u_tgt (
    .pc_q     (pc_q),
    .rs1_val  (rs1_val),
    .imm_j    (imm_j),
    .imm_b    (imm_b),
    .imm_i    (imm_i),
    .tgt_seq  (tgt_seq),
    .tgt_br   (tgt_br),
    .tgt_jal  (tgt_jal),
    .tgt_jalr (tgt_jalr)
  );

  pc_src_select #(.XLEN(XLEN)) u_sel (
    .jump_en     (jump_en),
    .jalr_sel    (jalr_sel),
    .take_branch (take_branch),
    .tgt_seq     (tgt_seq),
    .tgt_br      (tgt_br),
    .tgt_jal     (tgt_jal),
    .tgt_jalr    (tgt_jalr),
    .src         (pc_src),
    .pc_d        (pc_d)
  );

  always_ff @(posedge clk) begin
    if (rst)             pc_q <= RESET_VEC;
    else if (inst_valid) pc_q <= pc_d;
  end

  assign pc       = pc_q;
  assign pc_plus4 = tgt_seq;

endmodule

// File: rtl/pc_next_chk.sv
module pc_next_chk #(
  parameter int unsigned     XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input logic            clk,
  input logic            rst,
  input logic            inst_valid,
  input logic            jump_en,
  input logic            jalr_sel,
  input logic [2:0]      br_sel,
  input logic [XLEN-1:0] rs1_val,
  input logic [XLEN-1:0] rs2_val,
  input logic            take_branch,
  input logic [1:0]      pc_src,
  input logic [XLEN-1:0] pc
);

  // R1
  reset_vec_chk: assert property (@(posedge clk) rst |=> pc == RESET_VEC);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inst_valid |=> $stable(pc));

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    inst_valid && !jump_en && !take_branch |=> pc == $past(pc) + XLEN'(4));

  // R5
  jalr_even_chk: assert property (@(posedge clk) disable iff (rst)
    inst_valid && jump_en && jalr_sel |=> pc[0] == 1'b0);

  // R9
  no_cond_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    (br_sel == 3'd0 || br_sel == 3'd7) |-> !take_branch);

  // R7
  ge_on_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (br_sel == 3'd4 || br_sel == 3'd6) && rs1_val == rs2_val |-> take_branch);

  // R10
  jump_wins_chk: assert property (@(posedge clk) disable iff (rst)
    jump_en |-> pc_src[1]);

endmodule

bind pc_next_unit pc_next_chk #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .inst_valid  (inst_valid),
  .jump_en     (jump_en),
  .jalr_sel    (jalr_sel),
  .br_sel      (br_sel),
  .rs1_val     (rs1_val),
  .rs2_val     (rs2_val),
  .take_branch (take_branch),
  .pc_src      (pc_src),
  .pc          (pc)
);

// File: tb/sim_pc_next_unit.sv
`timescale 1ns/1ps
module sim_pc_next_unit;

  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inst_valid = 1'b0;
  logic        jump_en = 1'b0;
  logic        jalr_sel = 1'b0;
  logic [2:0]  br_sel = 3'd0;
  logic [31:0] rs1_val = '0, rs2_val = '0, imm_j = '0, imm_b = '0, imm_i = '0;
  logic [31:0] pc, pc_plus4;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] exp_pc = RV;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pc_next_unit #(.XLEN(32), .RESET_VEC(RV)) u0 (
    .clk(clk), .rst(rst), .inst_valid(inst_valid), .jump_en(jump_en),
    .jalr_sel(jalr_sel), .br_sel(br_sel), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .imm_j(imm_j), .imm_b(imm_b), .imm_i(imm_i), .pc(pc), .pc_plus4(pc_plus4)
  );

  function automatic bit ref_take(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'd1: return a == b;
      3'd2: return a != b;
      3'd3: return $signed(a) < $signed(b);
      3'd4: return $signed(a) >= $signed(b);
      3'd5: return a < b;
      3'd6: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic je, input logic js, input logic [2:0] bs,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] ij,
                       input logic [31:0] ib, input logic [31:0] ii, input string req);
    logic [31:0] nxt;
    @(negedge clk);
    inst_valid = v; jump_en = je; jalr_sel = js; br_sel = bs;
    rs1_val = a; rs2_val = b; imm_j = ij; imm_b = ib; imm_i = ii;
    if (!v)                    nxt = exp_pc;
    else if (je && js)         nxt = (a + ii) & 32'hFFFF_FFFE;
    else if (je)               nxt = exp_pc + ij;
    else if (ref_take(bs, a, b)) nxt = exp_pc + ib;
    else                       nxt = exp_pc + 32'd4;
    @(posedge clk); #1;
    exp_pc = nxt;
    check(req, "pc", pc, exp_pc);
    check("R3", "pc_plus4", pc_plus4, exp_pc + 32'd4);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; inst_valid = 1'b1; jump_en = 1'b1; imm_j = 32'h40;
    @(posedge clk); #1;
    exp_pc = RV;
    check("R1", "pc", pc, RV);
    check("R1", "pc_plus4", pc_plus4, RV + 32'd4);
    @(negedge clk); rst = 1'b0; inst_valid = 1'b0; jump_en = 1'b0;
  endtask

  task automatic t_hold();
    apply(1'b0, 1'b1, 1'b0, 3'd0, '0, '0, 32'h100, '0, '0, "R2");
    apply(1'b0, 1'b0, 1'b0, 3'd1, 32'h5, 32'h5, '0, 32'h80, '0, "R2");
    check("R2", "pc after idle", pc, RV);
  endtask

  task automatic t_seq();
    apply(1'b1, 1'b0, 1'b0, 3'd0, 32'h1, 32'h1, 32'h100, 32'h200, '0, "R3");
    check("R3", "pc step", pc, RV + 32'd4);
  endtask

  task automatic t_jal();
    apply(1'b1, 1'b1, 1'b0, 3'd0, '0, '0, 32'h100, '0, '0, "R4");
    check("R4", "jal fwd", pc, 32'h0000_1104);
    apply(1'b1, 1'b1, 1'b0, 3'd0, '0, '0, 32'hFFFF_FFF8, '0, '0, "R4");
    check("R4", "jal back", pc, 32'h0000_10FC);
  endtask

  task automatic t_jalr();
    apply(1'b1, 1'b1, 1'b1, 3'd0, 32'h2001, '0, '0, '0, 32'h10, "R5");
    check("R5", "jalr odd sum", pc, 32'h0000_2010);
    apply(1'b1, 1'b1, 1'b1, 3'd0, 32'h3000, '0, '0, '0, 32'hFFFF_FFFD, "R5");
    check("R5", "jalr neg ofs", pc, 32'h0000_2FFC);
  endtask

  task automatic t_eq_ne();
    apply(1'b1, 1'b0, 1'b0, 3'd1, 32'h77, 32'h77, '0, 32'h40, '0, "R6");
    apply(1'b1, 1'b0, 1'b0, 3'd1, 32'h77, 32'h78, '0, 32'h40, '0, "R6");
    apply(1'b1, 1'b0, 1'b0, 3'd2, 32'h77, 32'h78, '0, 32'h40, '0, "R6");
    apply(1'b1, 1'b0, 1'b0, 3'd2, 32'h77, 32'h77, '0, 32'h40, '0, "R6");
  endtask

  task automatic t_signed();
    apply(1'b1, 1'b0, 1'b0, 3'd3, 32'hFFFF_FFFF, 32'h1, '0, 32'h20, '0, "R7");
    apply(1'b1, 1'b0, 1'b0, 3'd3, 32'h1, 32'hFFFF_FFFF, '0, 32'h20, '0, "R7");
    apply(1'b1, 1'b0, 1'b0, 3'd4, 32'hFFFF_FFFF, 32'h1, '0, 32'h20, '0, "R7");
    apply(1'b1, 1'b0, 1'b0, 3'd4, 32'h8000_0000, 32'h8000_0000, '0, 32'hFFFF_FFF0, '0, "R7");
    apply(1'b1, 1'b0, 1'b0, 3'd3, 32'h8000_0000, 32'h7FFF_FFFF, '0, 32'h20, '0, "R7");
  endtask

  task automatic t_unsigned();
    apply(1'b1, 1'b0, 1'b0, 3'd5, 32'hFFFF_FFFF, 32'h1, '0, 32'h20, '0, "R8");
    apply(1'b1, 1'b0, 1'b0, 3'd5, 32'h1, 32'hFFFF_FFFF, '0, 32'h20, '0, "R8");
    apply(1'b1, 1'b0, 1'b0, 3'd6, 32'hFFFF_FFFF, 32'h1, '0, 32'h20, '0, "R8");
    apply(1'b1, 1'b0, 1'b0, 3'd6, 32'h1234, 32'h1234, '0, 32'h20, '0, "R8");
    apply(1'b1, 1'b0, 1'b0, 3'd6, 32'h0, 32'h8000_0000, '0, 32'h20, '0, "R8");
  endtask

  task automatic t_no_cond();
    apply(1'b1, 1'b0, 1'b0, 3'd0, 32'h9, 32'h9, '0, 32'h400, '0, "R9");
    apply(1'b1, 1'b0, 1'b0, 3'd7, 32'h9, 32'h9, '0, 32'h400, '0, "R9");
    apply(1'b1, 1'b0, 1'b0, 3'd7, 32'h1, 32'h9, '0, 32'h400, '0, "R9");
  endtask

  task automatic t_priority();
    apply(1'b1, 1'b1, 1'b0, 3'd1, 32'h5, 32'h5, 32'h8, 32'h800, '0, "R10");
    apply(1'b1, 1'b1, 1'b1, 3'd6, 32'h4000, 32'h0, '0, 32'h800, 32'h4, "R10");
    check("R10", "indirect over branch", pc, 32'h0000_4004);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hold();
    t_seq();
    t_jal();
    t_jalr();
    t_eq_ne();
    t_signed();
    t_unsigned();
    t_no_cond();
    t_priority();
    t_reset();
    t_seq();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule